// File: doc/BRIEF.md
# Message Time-Stamp and Deadline Unit

This block keeps a free-running time counter for a bank of message mailboxes. Each time a mailbox finishes a transfer in either direction, the counter value is captured into that mailbox's stamp register. Software can then read the stamp to learn when the message completed. Each mailbox also has a deadline value, a deadline enable and an armed state. An armed, enabled mailbox that reaches its deadline before completing a transfer gets a sticky timeout flag. The interrupt line is active while any flag is set.

Software controls the unit through a single write port with four operations: load a deadline, set an enable, clear flags, and preload the counter. A mode input chooses between full operation and reduced operation. In reduced operation the counter, the captures and the timeout detection all stop. The caller provides the counter's tick enable and one completion strobe with a mailbox index.

Top module: `msg_tstamp_unit`

## Requirements
- R1: In full mode (`full_mode_i`=1), the counter goes up by one on each cycle with `tick_i`=1 and wraps from all-ones to zero. Operation code 3 (`cfg_op_i`=2'd3 with `cfg_we_i`=1) loads `cfg_data_i` into the counter and takes priority over a tick.
- R2: Without a tick, or in reduced mode, the counter keeps its value.
- R3: A completion strobe (`done_vld_i`=1) in full mode stores the counter value of that cycle into the stamp of mailbox `done_idx_i`. The stamp shows on `stamp_rd_o` in the next cycle when `rd_idx_i` selects that mailbox.
- R4: Operation code 0 writes `cfg_data_i` as the deadline of mailbox `cfg_idx_i` and arms it. An armed mailbox with its enable set, seen with the counter equal to its deadline, sets its flag (bit i of `flags_o`) in the next cycle and disarms. The timeout fires only once per arming.
- R5: A completion of a mailbox disarms it. A completion in the same cycle as the deadline match suppresses the flag.
- R6: Operation code 1 writes `cfg_data_i[0]` as the enable of mailbox `cfg_idx_i`. With the enable clear, no flag is set for that mailbox.
- R7: Flags stay set until operation code 2 clears every flag whose bit in `cfg_data_i` is 1. A new timeout in the same cycle as its clear leaves the flag set.
- R8: `irq_o` is 1 exactly when at least one flag is set.
- R9: In reduced mode (`full_mode_i`=0), completions are ignored: no stamp changes and no disarming. No flag is set. The armed state is kept, so a pending match fires once full mode returns.
- R10: After reset the counter, all stamps, deadlines, enables and flags are zero, and no mailbox is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_mode_i | input | 1 | 1 = full operation, 0 = reduced operation |
| tick_i | input | 1 | Counter advance enable |
| done_vld_i | input | 1 | Mailbox transfer completion strobe |
| done_idx_i | input | IDX_W | Mailbox that completed |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | 0 deadline, 1 enable, 2 clear flags, 3 load counter |
| cfg_idx_i | input | IDX_W | Mailbox addressed by operations 0 and 1 |
| cfg_data_i | input | CNT_W | Deadline, enable bit, clear mask or counter value |
| rd_idx_i | input | IDX_W | Mailbox whose stamp is shown |
| cnt_o | output | CNT_W | Current counter value |
| stamp_rd_o | output | CNT_W | Stamp of mailbox `rd_idx_i` |
| flags_o | output | NUM_MBX | Timeout flags |
| irq_o | output | 1 | Timeout interrupt |

## Verification
All state is registered, so every write, tick, completion and timeout shows on the outputs one cycle after the edge on which it was sampled. `stamp_rd_o` is combinational from `rd_idx_i` and shows the stamp register as it is. A timeout flag appears one cycle after the cycle in which the registered counter equals the deadline. The bench drives inputs just after a rising edge and steps its reference model by one cycle per edge. It compares the counter, flags, interrupt and selected stamp one time unit after each edge.

// File: rtl/mts_pkg.sv
package mts_pkg;
  typedef enum logic [1:0] {
    OP_LIMIT  = 2'd0,
    OP_ENABLE = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_LOAD   = 2'd3
  } cfg_op_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mts_counter.sv
module mts_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic             run,
    input logic             ld,
    input logic [CNT_W-1:0] val
  );
    if (ld) return val;
    if (run) return cur + ONE;
    return cur;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step_count(cnt_q, run_i, ld_i, ld_val_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mts_stamp_bank.sv
module mts_stamp_bank #(
  parameter int NUM_MBX = 32,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = mts_pkg::idx_width(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MBX-1:0] cap_vec_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]   stamp_o
);
  logic [NUM_MBX-1:0][CNT_W-1:0] stamp_w;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_slot
    logic [CNT_W-1:0] stamp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            stamp_q <= '0;
      else if (cap_vec_i[i]) stamp_q <= cnt_i;
    end
    assign stamp_w[i] = stamp_q;
  end

  always_comb begin
    stamp_o = '0;
    for (int i = 0; i < NUM_MBX; i++) begin
      if (rd_idx_i == IDX_W'(i)) stamp_o = stamp_w[i];
    end
  end
endmodule

// File: rtl/mts_deadline.sv
module mts_deadline #(
  parameter int NUM_MBX = 32,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NUM_MBX-1:0] done_vec_i,
  input  logic [NUM_MBX-1:0] lim_we_vec_i,
  input  logic [NUM_MBX-1:0] en_we_vec_i,
  input  logic [CNT_W-1:0]   wr_val_i,
  input  logic               clr_we_i,
  input  logic [NUM_MBX-1:0] clr_mask_i,
  output logic [NUM_MBX-1:0] hit_vec_o,
  output logic [NUM_MBX-1:0] flags_o
);
  function automatic logic deadline_hit(
    input logic             full,
    input logic             en,
    input logic             armed,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic             done
  );
    return full && en && armed && (cnt == lim) && !done;
  endfunction

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
    logic [CNT_W-1:0] lim_q;
    logic             en_q;
    logic             arm_q;
    logic             flag_q;
    logic             hit;
    logic             clr;

    assign hit = deadline_hit(full_i, en_q, arm_q, cnt_i, lim_q, done_vec_i[i]);
    assign clr = clr_we_i && clr_mask_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q  <= '0;
        en_q   <= 1'b0;
        arm_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        if (lim_we_vec_i[i]) lim_q <= wr_val_i;
        if (en_we_vec_i[i])  en_q  <= wr_val_i[0];
        if (lim_we_vec_i[i])                arm_q <= 1'b1;
        else if (done_vec_i[i] || hit)      arm_q <= 1'b0;
        flag_q <= (flag_q && !clr) || hit;
      end
    end

    assign hit_vec_o[i] = hit;
    assign flags_o[i]   = flag_q;
  end
endmodule

// File: rtl/msg_tstamp_unit.sv
module msg_tstamp_unit #(
  parameter int NUM_MBX = 32,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = mts_pkg::idx_width(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_mode_i,
  input  logic               tick_i,
  input  logic               done_vld_i,
  input  logic [IDX_W-1:0]   done_idx_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_op_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [CNT_W-1:0]   cfg_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   stamp_rd_o,
  output logic [NUM_MBX-1:0] flags_o,
  output logic               irq_o
);
  import mts_pkg::*;

  cfg_op_e            op;
  logic               ld_evt;
  logic               clr_evt;
  logic               lim_evt;
  logic               en_evt;
  logic               run_evt;
  logic [NUM_MBX-1:0] done_vec;
  logic [NUM_MBX-1:0] lim_we_vec;
  logic [NUM_MBX-1:0] en_we_vec;
  logic [NUM_MBX-1:0] hit_vec;
  logic [CNT_W-1:0]   cnt_w;

  assign op      = cfg_op_e'(cfg_op_i);
  assign ld_evt  = cfg_we_i && (op == OP_LOAD);
  assign clr_evt = cfg_we_i && (op == OP_CLEAR);
  assign lim_evt = cfg_we_i && (op == OP_LIMIT);
  assign en_evt  = cfg_we_i && (op == OP_ENABLE);
  assign run_evt = full_mode_i && tick_i;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_dec
    assign done_vec[i]   = full_mode_i && done_vld_i && (done_idx_i == IDX_W'(i));
    assign lim_we_vec[i] = lim_evt && (cfg_idx_i == IDX_W'(i));
    assign en_we_vec[i]  = en_evt  && (cfg_idx_i == IDX_W'(i));
  end

  mts_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_evt),
    .ld_i     (ld_evt),
    .ld_val_i (cfg_data_i),
    .cnt_o    (cnt_w)
  );

  mts_stamp_bank #(.NUM_MBX(NUM_MBX), .CNT_W(CNT_W)) u_stamps (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_vec_i (done_vec),
    .cnt_i     (cnt_w),
    .rd_idx_i  (rd_idx_i),
    .stamp_o   (stamp_rd_o)
  );

  mts_deadline #(.NUM_MBX(NUM_MBX), .CNT_W(CNT_W)) u_deadline (
    .clk          (clk),
    .rst_n        (rst_n),
    .full_i       (full_mode_i),
    .cnt_i        (cnt_w),
    .done_vec_i   (done_vec),
    .lim_we_vec_i (lim_we_vec),
    .en_we_vec_i  (en_we_vec),
    .wr_val_i     (cfg_data_i),
    .clr_we_i     (clr_evt),
    .clr_mask_i   (cfg_data_i[NUM_MBX-1:0]),
    .hit_vec_o    (hit_vec),
    .flags_o      (flags_o)
  );

  assign cnt_o = cnt_w;
  assign irq_o = |flags_o;
endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
  parameter int NUM_MBX = 32,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = mts_pkg::idx_width(NUM_MBX)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               full_mode_i,
  input logic               tick_i,
  input logic               done_vld_i,
  input logic [IDX_W-1:0]   done_idx_i,
  input logic               cfg_we_i,
  input logic [1:0]         cfg_op_i,
  input logic [IDX_W-1:0]   rd_idx_i,
  input logic [CNT_W-1:0]   cnt_o,
  input logic [CNT_W-1:0]   stamp_rd_o,
  input logic [NUM_MBX-1:0] flags_o,
  input logic [NUM_MBX-1:0] hit_vec
);
  logic ld_c;
  logic clr_c;
  assign ld_c  = cfg_we_i && (cfg_op_i == 2'd3);
  assign clr_c = cfg_we_i && (cfg_op_i == 2'd2);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode_i && tick_i && !ld_c |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode_i || !tick_i) && !ld_c |=> $stable(cnt_o)); // R2

  AST_STAMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode_i && done_vld_i && (rd_idx_i == done_idx_i)
    |=> (rd_idx_i != $past(rd_idx_i)) || (stamp_rd_o == $past(cnt_o))); // R3

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    |hit_vec |=> (flags_o & $past(hit_vec)) == $past(hit_vec)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_c |=> (flags_o & $past(flags_o)) == $past(flags_o)); // R7

  AST_REDUCED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !full_mode_i |=> (flags_o & ~$past(flags_o)) == '0); // R9
endmodule

bind msg_tstamp_unit mts_checker #(.NUM_MBX(NUM_MBX), .CNT_W(CNT_W)) u_mts_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .full_mode_i (full_mode_i),
  .tick_i      (tick_i),
  .done_vld_i  (done_vld_i),
  .done_idx_i  (done_idx_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_op_i    (cfg_op_i),
  .rd_idx_i    (rd_idx_i),
  .cnt_o       (cnt_o),
  .stamp_rd_o  (stamp_rd_o),
  .flags_o     (flags_o),
  .hit_vec     (hit_vec)
);

// File: tb/test_msg_tstamp_unit.sv
module test_msg_tstamp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 32;
  localparam int CW = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          full_mode = 1'b1;
  logic          tick = 1'b0;
  logic          done_vld = 1'b0;
  logic [IW-1:0] done_idx = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_op = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stamp_rd;
  logic [NM-1:0] flags;
  logic          irq;

  int checks = 0;
  int fails = 0;

  logic [CW-1:0] m_cnt;
  logic [CW-1:0] m_stamp [NM];
  logic [CW-1:0] m_lim   [NM];
  logic          m_en    [NM];
  logic          m_arm   [NM];
  logic [NM-1:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_tstamp_unit #(.NUM_MBX(NM), .CNT_W(CW)) i_msg_tstamp_unit (
    .clk(clk), .rst_n(rst_n), .full_mode_i(full_mode), .tick_i(tick),
    .done_vld_i(done_vld), .done_idx_i(done_idx), .cfg_we_i(cfg_we),
    .cfg_op_i(cfg_op), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .rd_idx_i(rd_idx), .cnt_o(cnt), .stamp_rd_o(stamp_rd),
    .flags_o(flags), .irq_o(irq)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NM-1:0] hit_model();
    logic [NM-1:0] h;
    for (int i = 0; i < NM; i++) begin
      logic comp;
      comp = full_mode && done_vld && (done_idx == IW'(i));
      h[i] = full_mode && m_en[i] && m_arm[i] && (m_cnt == m_lim[i]) && !comp;
    end
    return h;
  endfunction

  task automatic model_step();
    logic [NM-1:0] h;
    logic [CW-1:0] c;
    h = hit_model();
    c = m_cnt;
    for (int i = 0; i < NM; i++) begin
      logic comp;
      logic clr;
      comp = full_mode && done_vld && (done_idx == IW'(i));
      clr  = cfg_we && cfg_op == 2'd2 && cfg_data[i];
      if (comp) m_stamp[i] = c;
      if (cfg_we && cfg_op == 2'd0 && cfg_idx == IW'(i)) begin
        m_lim[i] = cfg_data;
        m_arm[i] = 1'b1;
      end else if (comp || h[i]) begin
        m_arm[i] = 1'b0;
      end
      if (cfg_we && cfg_op == 2'd1 && cfg_idx == IW'(i)) m_en[i] = cfg_data[0];
      m_flags[i] = (m_flags[i] && !clr) || h[i];
    end
    if (cfg_we && cfg_op == 2'd3) m_cnt = cfg_data;
    else if (full_mode && tick)   m_cnt = c + 1;
  endtask

  task automatic cyc();
    string ctag;
    ctag = (full_mode && tick) || (cfg_we && cfg_op == 2'd3) ? "R1" : "R2";
    model_step();
    @(posedge clk);
    #1;
    check(ctag, "counter", cnt, m_cnt);
    check("R4", "flags", flags, m_flags);
    check("R8", "irq", irq, |m_flags);
    check("R3", "stamp", stamp_rd, m_stamp[rd_idx]);
  endtask

  task automatic idle();
    tick = 0; done_vld = 0; cfg_we = 0;
  endtask

  task automatic wr(input logic [1:0] op, input int idx, input logic [CW-1:0] d);
    cfg_we = 1; cfg_op = op; cfg_idx = IW'(idx); cfg_data = d;
    cyc();
    cfg_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = '0; m_flags = '0;
    for (int i = 0; i < NM; i++) begin
      m_stamp[i] = '0; m_lim[i] = '0; m_en[i] = 0; m_arm[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    check("R10", "cnt after reset", cnt, 0);
    check("R10", "flags after reset", flags, 0);
    check("R10", "irq after reset", irq, 0);
    for (int i = 0; i < 4; i++) begin
      rd_idx = IW'(i * 9);
      #1 check("R10", "stamp after reset", stamp_rd, 0);
    end
    rd_idx = 0;
    // R10 enable and deadline zero: counter at 0 causes no flag (not armed)
    cyc();
    check("R10", "no flag while disarmed", flags, 0);

    // R1 wrap
    wr(2'd3, 0, 32'hFFFF_FFFE);
    tick = 1; cyc(); cyc(); cyc(); tick = 0;
    check("R1", "wrap value", cnt, 1);
    // R2 hold
    cyc(); cyc();
    check("R2", "hold without tick", cnt, 1);

    // R3 capture
    wr(2'd3, 0, 32'h0000_1000);
    rd_idx = 5; done_vld = 1; done_idx = 5; tick = 1;
    cyc(); idle();
    check("R3", "stamp of mailbox 5", stamp_rd, 32'h0000_1000);

    // R4 timeout one-shot
    wr(2'd1, 3, 1);
    wr(2'd0, 3, 32'h0000_1004);
    tick = 1;
    for (int k = 0; k < 6; k++) cyc();
    tick = 0;
    check("R4", "flag 3 set", flags[3], 1);
    check("R8", "irq with flag", irq, 1);
    wr(2'd2, 0, 32'h0000_0008);
    check("R7", "flag 3 cleared", flags[3], 0);
    wr(2'd3, 0, 32'h0000_1004);
    cyc(); cyc();
    check("R4", "no refire after disarm", flags[3], 0);

    // R5 completion before deadline, and coincident completion
    wr(2'd1, 7, 1);
    wr(2'd0, 7, cnt + 3);
    tick = 1; cyc();
    done_vld = 1; done_idx = 7; cyc(); done_vld = 0;
    for (int k = 0; k < 5; k++) cyc();
    tick = 0;
    check("R5", "early completion no flag", flags[7], 0);
    wr(2'd0, 7, cnt);
    done_vld = 1; done_idx = 7; cyc(); done_vld = 0;
    cyc(); cyc();
    check("R5", "coincident completion no flag", flags[7], 0);

    // R6 enable clear
    wr(2'd1, 9, 0);
    wr(2'd0, 9, cnt + 1);
    tick = 1; repeat (4) cyc(); tick = 0;
    check("R6", "disabled mailbox no flag", flags[9], 0);

    // R9 reduced mode
    wr(2'd1, 11, 1);
    wr(2'd0, 11, cnt);
    full_mode = 0; rd_idx = 11;
    done_vld = 1; done_idx = 11; tick = 1;
    cyc(); cyc(); idle();
    check("R9", "no flag in reduced", flags[11], 0);
    check("R9", "no stamp in reduced", stamp_rd, 0);
    full_mode = 1;
    cyc(); cyc();
    check("R9", "pending match fires on return", flags[11], 1);

    // R7 set wins over clear in same cycle
    wr(2'd1, 12, 1);
    wr(2'd0, 12, cnt + 1);
    wr(2'd3, 0, cnt + 1);
    wr(2'd2, 0, 32'h0000_1000);
    check("R7", "set beats clear", flags[12], 1);
    wr(2'd2, 0, 32'hFFFF_FFFF);
    check("R7", "clear all", flags, 0);
    check("R8", "irq low after clear", irq, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      full_mode = ($urandom % 10) != 0;
      tick      = $urandom % 2;
      done_vld  = ($urandom % 5) == 0;
      done_idx  = IW'($urandom);
      rd_idx    = IW'($urandom);
      r = $urandom % 10;
      cfg_we = r < 5;
      cfg_idx = IW'($urandom);
      case (r)
        0, 1:    begin cfg_op = 2'd0; cfg_data = m_cnt + ($urandom % 12); end
        2, 3:    begin cfg_op = 2'd1; cfg_data = CW'($urandom % 4 != 0); end
        4:       begin cfg_op = ($urandom % 3 == 0) ? 2'd3 : 2'd2; cfg_data = $urandom; end
        default: begin cfg_op = 2'd0; cfg_data = '0; end
      endcase
      cyc();
    end
    idle();
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule